// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block collects level-sensitive interrupt sources arranged in banks (five banks of 32 sources by default). It keeps a sticky pending bit for every source and an enable mask per bank. A register bus gives software single-cycle access, with a write strobe and combinational read data. Each bank raises one request line whenever any of its sources is both pending and enabled, and it reports the number of the highest such source.

Across banks, a ranking picks the lowest-numbered bank that is requesting and reports its index, so a processor with one input per bank can service them in a fixed order. Software clears a pending bit by writing a one to it. It can also read the live source inputs, and it has a spare read/write word per bank that has no effect on behaviour.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every pending bit, enable bit and mode word is zero, and no bank requests.
- R2: A pending bit becomes 1 at every rising clock edge where its source input is high. It stays 1 after the source returns low, until software clears it.
- R3: Writing the pending word (bank offset 0x00) clears each bit written as 1 and leaves bits written as 0 unchanged. If the source is high in the same cycle, setting wins and the bit stays 1.
- R4: The enable word (offset 0x08) reads back what was written. The masked word (offset 0x10) reads pending AND enable, and a bank's request line is 1 exactly when its masked word is nonzero.
- R5: The 5-bit winner index of a bank equals the position of the most significant set bit of its masked word. Bank b uses bits [5b+4:5b] of `bankWinner`.
- R6: Offset 0x18 reads the current, unregistered source inputs of the bank. Source bit j of bank b is `srcIn[32b+j]`.
- R7: Offset 0x20 is a read/write mode word per bank. Its value does not change any request or winner.
- R8: Bank b occupies byte addresses 0x28*b to 0x28*b+0x27, so bank 2 starts at 0x50 and bank 4 at 0xA0.
- R9: `winBank` names the lowest-numbered bank whose request is 1, and `anyReq` is 1 when any bank requests. With no request, `winBank` is 0.
- R10: Writes to the masked word, to the source word, or to an address outside every bank change no state. Reads outside every bank return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | 160 | Level source inputs, 32 per bank |
| regAddr | input | 8 | Register byte address |
| regWe | input | 1 | Write strobe, committed at the next rising edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for `regAddr` |
| bankReq | output | 5 | Request line per bank |
| bankWinner | output | 25 | Highest pending-and-enabled source index per bank |
| anyReq | output | 1 | Some bank requests |
| winBank | output | 3 | Lowest-numbered requesting bank |

## Verification
Read data, the source word, requests, winners and the bank ranking are combinational from the registers. The bench therefore compares them 2 ns after the falling edge at which the address is driven. A source pulse or register write becomes visible one rising edge after it is applied, so those checks are queued one falling edge later. The same-cycle set-over-clear case is the exception: it is checked at the first falling edge after the write edge, before a second edge could set the bit again.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
  localparam int BANK_IDX_W = 3;
  localparam int OFF_STATUS = 'h00;
  localparam int OFF_ENABLE = 'h08;
  localparam int OFF_MASKED = 'h10;
  localparam int OFF_RAW    = 'h18;
  localparam int OFF_MODE   = 'h20;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_ENABLE, SEL_MASKED, SEL_RAW, SEL_MODE
  } regSel_e;

  typedef struct packed {
    logic                  clrStatus;
    logic                  wrEnable;
    logic                  wrMode;
    logic [BANK_IDX_W-1:0] bank;
    regSel_e               rdSel;
  } regStrobe_t;
endpackage

// File: rtl/irq_reg_decode.sv
`timescale 1ns/1ps
module irq_reg_decode
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_BANKS   = 5,
  parameter int ADDR_WIDTH  = 8,
  parameter int BANK_STRIDE = 'h28
) (
  input  logic [ADDR_WIDTH-1:0] regAddr,
  input  logic                  regWe,
  output regStrobe_t            strobe
);
  always_comb begin
    int addrInt;
    int offset;
    strobe       = '0;
    strobe.rdSel = SEL_NONE;
    addrInt      = int'(regAddr);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addrInt >= b * BANK_STRIDE && addrInt < (b + 1) * BANK_STRIDE) begin
        offset      = addrInt - b * BANK_STRIDE;
        strobe.bank = BANK_IDX_W'(b);
        case (offset)
          OFF_STATUS: begin strobe.rdSel = SEL_STATUS; strobe.clrStatus = regWe; end
          OFF_ENABLE: begin strobe.rdSel = SEL_ENABLE; strobe.wrEnable  = regWe; end
          OFF_MASKED: strobe.rdSel = SEL_MASKED;
          OFF_RAW:    strobe.rdSel = SEL_RAW;
          OFF_MODE:   begin strobe.rdSel = SEL_MODE;   strobe.wrMode    = regWe; end
          default:    strobe.rdSel = SEL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_bank_datapath.sv
`timescale 1ns/1ps
module irq_bank_datapath
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int SRC_WIDTH = 32,
  localparam int TOTAL_W  = NUM_BANKS * SRC_WIDTH
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TOTAL_W-1:0]   srcIn,
  input  regStrobe_t           strobe,
  input  logic [SRC_WIDTH-1:0] wrData,
  output logic [SRC_WIDTH-1:0] rdData,
  output logic [TOTAL_W-1:0]   statusVec,
  output logic [TOTAL_W-1:0]   enableVec,
  output logic [TOTAL_W-1:0]   maskedVec
);
  logic [SRC_WIDTH-1:0] modeQ [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic                 bankHit;
    logic [SRC_WIDTH-1:0] statusQ;
    logic [SRC_WIDTH-1:0] enableQ;
    logic [SRC_WIDTH-1:0] clrMask;
    logic [SRC_WIDTH-1:0] srcBank;

    assign bankHit = (strobe.bank == BANK_IDX_W'(b));
    assign srcBank = srcIn[b*SRC_WIDTH +: SRC_WIDTH];
    assign clrMask = (strobe.clrStatus && bankHit) ? wrData : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusQ  <= '0;
        enableQ  <= '0;
        modeQ[b] <= '0;
      end else begin
        statusQ <= (statusQ & ~clrMask) | srcBank;
        if (strobe.wrEnable && bankHit) enableQ  <= wrData;
        if (strobe.wrMode && bankHit)   modeQ[b] <= wrData;
      end
    end

    assign statusVec[b*SRC_WIDTH +: SRC_WIDTH] = statusQ;
    assign enableVec[b*SRC_WIDTH +: SRC_WIDTH] = enableQ;
    assign maskedVec[b*SRC_WIDTH +: SRC_WIDTH] = statusQ & enableQ;
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobe.bank == BANK_IDX_W'(b)) begin
        case (strobe.rdSel)
          SEL_STATUS: rdData = statusVec[b*SRC_WIDTH +: SRC_WIDTH];
          SEL_ENABLE: rdData = enableVec[b*SRC_WIDTH +: SRC_WIDTH];
          SEL_MASKED: rdData = maskedVec[b*SRC_WIDTH +: SRC_WIDTH];
          SEL_RAW:    rdData = srcIn[b*SRC_WIDTH +: SRC_WIDTH];
          SEL_MODE:   rdData = modeQ[b];
          default:    rdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_msb_encoder.sv
`timescale 1ns/1ps
module irq_msb_encoder #(
  parameter int  WIDTH = 32,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [IDX_W-1:0] idxOut,
  output logic             anySet
);
  always_comb begin
    idxOut = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vecIn[i]) idxOut = IDX_W'(i);
    end
  end
  assign anySet = |vecIn;
endmodule

// File: rtl/banked_irq_ctrl.sv
`timescale 1ns/1ps
module banked_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int  NUM_BANKS   = 5,
  parameter int  SRC_WIDTH   = 32,
  parameter int  ADDR_WIDTH  = 8,
  parameter int  BANK_STRIDE = 'h28,
  localparam int IDX_W       = $clog2(SRC_WIDTH),
  localparam int TOTAL_W     = NUM_BANKS * SRC_WIDTH
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [TOTAL_W-1:0]           srcIn,
  input  logic [ADDR_WIDTH-1:0]        regAddr,
  input  logic                         regWe,
  input  logic [SRC_WIDTH-1:0]         regWdata,
  output logic [SRC_WIDTH-1:0]         regRdata,
  output logic [NUM_BANKS-1:0]         bankReq,
  output logic [NUM_BANKS*IDX_W-1:0]   bankWinner,
  output logic                         anyReq,
  output logic [BANK_IDX_W-1:0]        winBank
);
  regStrobe_t         strobe;
  logic [TOTAL_W-1:0] statusVec;
  logic [TOTAL_W-1:0] enableVec;
  logic [TOTAL_W-1:0] maskedVec;

  irq_reg_decode #(
    .NUM_BANKS(NUM_BANKS), .ADDR_WIDTH(ADDR_WIDTH), .BANK_STRIDE(BANK_STRIDE)
  ) decode_i (
    .regAddr(regAddr), .regWe(regWe), .strobe(strobe)
  );

  irq_bank_datapath #(
    .NUM_BANKS(NUM_BANKS), .SRC_WIDTH(SRC_WIDTH)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strobe(strobe), .wrData(regWdata),
    .rdData(regRdata), .statusVec(statusVec), .enableVec(enableVec),
    .maskedVec(maskedVec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_enc
    irq_msb_encoder #(.WIDTH(SRC_WIDTH)) enc_i (
      .vecIn (maskedVec[b*SRC_WIDTH +: SRC_WIDTH]),
      .idxOut(bankWinner[b*IDX_W +: IDX_W]),
      .anySet(bankReq[b])
    );
  end

  always_comb begin
    winBank = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (bankReq[b]) winBank = BANK_IDX_W'(b);
    end
  end
  assign anyReq = |bankReq;
endmodule

// File: rtl/irq_ctrl_checker.sv
`timescale 1ns/1ps
module irq_ctrl_checker #(
  parameter int  NUM_BANKS  = 5,
  parameter int  SRC_WIDTH  = 32,
  parameter int  ADDR_WIDTH = 8,
  localparam int IDX_W      = $clog2(SRC_WIDTH),
  localparam int TOTAL_W    = NUM_BANKS * SRC_WIDTH
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [TOTAL_W-1:0]         srcIn,
  input logic [ADDR_WIDTH-1:0]      regAddr,
  input logic                       regWe,
  input logic [SRC_WIDTH-1:0]       regWdata,
  input logic [NUM_BANKS-1:0]       bankReq,
  input logic [NUM_BANKS*IDX_W-1:0] bankWinner,
  input logic                       anyReq,
  input logic [2:0]                 winBank,
  input logic [TOTAL_W-1:0]         statusVec,
  input logic [TOTAL_W-1:0]         enableVec
);
  p_src_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusVec & $past(srcIn)) == $past(srcIn)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == '0) |=>
      ((statusVec[SRC_WIDTH-1:0] & $past(regWdata & ~srcIn[SRC_WIDTH-1:0])) == '0));

  p_enable_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable(enableVec));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    logic [SRC_WIDTH-1:0] mskB;
    assign mskB = statusVec[b*SRC_WIDTH +: SRC_WIDTH] & enableVec[b*SRC_WIDTH +: SRC_WIDTH];

    p_req_r4: assert property (@(posedge clk) disable iff (!rstN)
      bankReq[b] == (mskB != '0));

    p_win_msb_r5: assert property (@(posedge clk) disable iff (!rstN)
      bankReq[b] |-> ((mskB >> bankWinner[b*IDX_W +: IDX_W]) == SRC_WIDTH'(1)));
  end

  p_win_lowest_r9: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> ((((bankReq >> winBank) & NUM_BANKS'(1)) == NUM_BANKS'(1)) &&
                ((bankReq & ((NUM_BANKS'(1) << winBank) - NUM_BANKS'(1))) == '0)));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |-> (winBank == '0));
endmodule

bind banked_irq_ctrl irq_ctrl_checker #(
  .NUM_BANKS(NUM_BANKS), .SRC_WIDTH(SRC_WIDTH), .ADDR_WIDTH(ADDR_WIDTH)
) checker_i (
  .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr), .regWe(regWe),
  .regWdata(regWdata), .bankReq(bankReq), .bankWinner(bankWinner),
  .anyReq(anyReq), .winBank(winBank), .statusVec(statusVec), .enableVec(enableVec)
);

// File: tb/banked_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb_top;
  localparam int NB = 5;
  localparam int SW = 32;

  localparam int K_RDATA  = 0;
  localparam int K_REQ    = 1;
  localparam int K_WINNER = 2;
  localparam int K_WBANK  = 3;
  localparam int K_ANY    = 4;

  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NB*SW-1:0]  srcIn = '0;
  logic [7:0]        regAddr = '0;
  logic              regWe = 1'b0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic [NB-1:0]     bankReq;
  logic [NB*5-1:0]   bankWinner;
  logic              anyReq;
  logic [2:0]        winBank;

  item_t expQ[$];
  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  banked_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .bankReq(bankReq),
    .bankWinner(bankWinner), .anyReq(anyReq), .winBank(winBank)
  );

  task automatic pushNow(int kind, int idx, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic expectRead(logic [7:0] addr, logic [31:0] exp, string tag);
    @(negedge clk);
    regAddr = addr;
    pushNow(K_RDATA, int'(addr), exp, tag);
  endtask

  task automatic expectOut(int kind, int idx, logic [31:0] exp, string tag);
    @(negedge clk);
    pushNow(kind, idx, exp, tag);
  endtask

  task automatic regWrite(logic [7:0] addr, logic [31:0] data);
    @(negedge clk);
    regAddr = addr; regWdata = data; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pulseSrc(int bit0, int bit1);
    @(negedge clk);
    if (bit0 >= 0) srcIn[bit0] = 1'b1;
    if (bit1 >= 0) srcIn[bit1] = 1'b1;
    @(negedge clk);
    srcIn = '0;
  endtask

  // Monitor: compares queued expectations 2 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        case (it.kind)
          K_RDATA:  act = regRdata;
          K_REQ:    act = 32'(bankReq);
          K_WINNER: act = 32'(bankWinner[it.idx*5 +: 5]);
          K_WBANK:  act = 32'(winBank);
          default:  act = 32'(anyReq);
        endcase
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                   it.tag, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectRead(8'h00, 32'h0, "R1 status");
    expectRead(8'h08, 32'h0, "R1 enable");
    expectRead(8'h20, 32'h0, "R1 mode");
    expectOut(K_REQ, 0, 32'h0, "R1 bankReq");
    expectOut(K_ANY, 0, 32'h0, "R1 anyReq");

    // R2 sticky set, R4 masked while disabled
    pulseSrc(5, -1);
    expectRead(8'h00, 32'h0000_0020, "R2 sticky");
    expectRead(8'h10, 32'h0, "R4 masked disabled");
    expectOut(K_REQ, 0, 32'h0, "R4 no req disabled");

    // R4 enable, R5 winner
    regWrite(8'h08, 32'h0000_0220);
    expectRead(8'h08, 32'h0000_0220, "R4 enable readback");
    expectRead(8'h10, 32'h0000_0020, "R4 masked");
    expectOut(K_REQ, 0, 32'h1, "R4 bank0 req");
    expectOut(K_WINNER, 0, 32'd5, "R5 winner 5");

    pulseSrc(9, 3);
    expectRead(8'h00, 32'h0000_0228, "R2 accumulate");
    expectRead(8'h10, 32'h0000_0220, "R4 masked two");
    expectOut(K_WINNER, 0, 32'd9, "R5 msb wins");

    // R3 write one to clear
    regWrite(8'h00, 32'h0000_0200);
    expectRead(8'h00, 32'h0000_0028, "R3 clear bit9");
    expectOut(K_WINNER, 0, 32'd5, "R5 after clear");
    regWrite(8'h00, 32'h0);
    expectRead(8'h00, 32'h0000_0028, "R3 zero write");

    // R3 set wins over clear in same cycle
    @(negedge clk);
    srcIn[3] = 1'b1;
    regWrite(8'h00, 32'h0000_0008);
    pushNow(K_RDATA, 0, 32'h0000_0028, "R3 set over clear");
    @(negedge clk);
    srcIn[3] = 1'b0;
    regWrite(8'h00, 32'h0000_0028);
    expectRead(8'h00, 32'h0, "R3 clear all");
    expectOut(K_REQ, 0, 32'h0, "R4 req drops");

    // R6 raw live inputs
    @(negedge clk);
    srcIn[7:0] = 8'hA5;
    regAddr = 8'h18;
    pushNow(K_RDATA, 24, 32'h0000_00A5, "R6 raw live");
    @(negedge clk);
    srcIn = '0;
    pushNow(K_RDATA, 24, 32'h0, "R6 raw follows");
    regWrite(8'h00, 32'h0000_00FF);

    // R8 bank addressing, R9 ranking
    regWrite(8'h58, 32'h8000_0001);
    regWrite(8'hA8, 32'h0000_0001);
    pulseSrc(2*SW + 31, 4*SW + 0);
    expectRead(8'h60, 32'h8000_0000, "R8 bank2 masked");
    expectRead(8'hA0, 32'h0000_0001, "R8 bank4 status");
    expectOut(K_REQ, 0, 32'h14, "R8 bank reqs");
    expectOut(K_WBANK, 0, 32'd2, "R9 lowest bank");
    expectOut(K_WINNER, 2, 32'd31, "R5 bank2 winner");
    regWrite(8'h50, 32'h8000_0000);
    expectOut(K_WBANK, 0, 32'd4, "R9 next bank");
    expectOut(K_WINNER, 4, 32'd0, "R5 bank4 winner");
    expectOut(K_ANY, 0, 32'h1, "R9 anyReq");
    regWrite(8'hA0, 32'h0000_0001);
    expectOut(K_ANY, 0, 32'h0, "R9 idle");
    expectOut(K_WBANK, 0, 32'd0, "R9 idle bank");

    // R7 mode word
    regWrite(8'h20, 32'hDEAD_BEEF);
    expectRead(8'h20, 32'hDEAD_BEEF, "R7 mode bank0");
    regWrite(8'hC0, 32'h1234_5678);
    expectRead(8'hC0, 32'h1234_5678, "R7 mode bank4");
    expectRead(8'h20, 32'hDEAD_BEEF, "R8 mode isolated");
    expectOut(K_REQ, 0, 32'h0, "R7 no effect");

    // R10 ignored writes and unmapped reads
    pulseSrc(1, -1);
    regWrite(8'h10, 32'hFFFF_FFFF);
    regWrite(8'h18, 32'hFFFF_FFFF);
    regWrite(8'hC8, 32'hFFFF_FFFF);
    expectRead(8'h00, 32'h0000_0002, "R10 status kept");
    expectRead(8'h08, 32'h0000_0220, "R10 enable kept");
    expectRead(8'hC8, 32'h0, "R10 unmapped read");
    expectRead(8'hF0, 32'h0, "R10 high read");
    expectOut(K_REQ, 0, 32'h0, "R10 no req");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule